// File: doc/BRIEF.md
# Vertical Norm Hysteresis Counter

This block judges how steadily the vertical sync pulse falls inside the expected window. Once per field it receives a strobe. With the strobe comes a bit that says whether the pulse was found in the window. A saturating up/down count is built from these results. The count is split into three bands: norm, near-norm and no-norm. The vertical window controller uses the band to pick a narrow, medium or wide search window.

Misses cost more than hits in the middle of the range. When the count falls out of the two upper bands, it lands just below them and does not drop further. A stream that alternates between a good field and a bad field cannot climb in the upper bands. This is because, in those bands, a good pulse that follows a bad one is scored as bad. A sync-lost flag and a forced-wide-window control both send the block straight to no-norm, so the widest window is used.

Top module: `vnorm_counter`

## Requirements
- R1: After asynchronous reset the count is 0, `status_o` is 2'b00 (no-norm) and `norm_o` is 0.
- R2: A strobe with the pulse found, when it is not penalised, raises the count by 1. The count saturates at 27.
- R3: A strobe with a miss lowers the count by 2 when 10 < count < 26, and by 1 otherwise. The count never goes below 0.
- R4: In near-norm or norm, the first found pulse after one or more misses is scored as a miss, and the next found pulse counts normally. In no-norm a found pulse after a miss counts up at once.
- R5: A decrement that starts at a count of 12 or more never gives a result below 11.
- R6: `status_o` is 2'b10 (norm) when the count is above 22. It is 2'b01 (near-norm) when the count is 12 to 22. It is 2'b00 (no-norm) when the count is below 12.
- R7: `norm_o` is high exactly when the status is norm.
- R8: With sync-lost and forced-wide-window both low, the count changes only on a clock where `field_end_i` is high.
- R9: On any clock where `sync_lost_i` is high, the count becomes 0.
- R10: While `force_wide_i` is high, the count stays 0, whatever strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_end_i | input | 1 | One-cycle strobe at the end of each field |
| vsync_found_i | input | 1 | Pulse seen inside the window during this field |
| sync_lost_i | input | 1 | Horizontal sync lock is lost |
| force_wide_i | input | 1 | Hold the block in no-norm |
| status_o | output | 2 | 00 no-norm, 01 near-norm, 10 norm |
| norm_o | output | 1 | High when the status is norm |
| count_o | output | 5 | Current count value |

## Verification
The bench goes after the edges of the double-step band:
- 26 must step down by one, and 25 must step down by two. A design with an inclusive band compare would show 24 in place of 25.
- A count of 12 that misses must stop at 11. Without the floor it would show 10.

The bench also feeds a miss followed by a hit at 26 in norm. A design without the penalty would climb back to 27 there. It then checks that the same pattern in no-norm climbs at once. It checks saturation at both ends of the range. Finally it checks that sync-lost and forced-wide clear the count even when no strobe is present.

// File: rtl/vnorm_pkg.sv
package vnorm_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_NEAR = 2'b01,
    ST_NORM = 2'b10
  } vnorm_status_e;
endpackage

// File: rtl/vnorm_classify.sv
module vnorm_classify
  import vnorm_pkg::*;
#(
  parameter int CW         = 5,
  parameter int NEAR_MIN   = 12,
  parameter int NORM_ABOVE = 22
) (
  input  logic [CW-1:0]  cnt_i,
  output vnorm_status_e  status_o
);
  localparam logic [CW-1:0] NearMin   = CW'(NEAR_MIN);
  localparam logic [CW-1:0] NormAbove = CW'(NORM_ABOVE);

  always_comb begin
    if (cnt_i > NormAbove)     status_o = ST_NORM;
    else if (cnt_i >= NearMin) status_o = ST_NEAR;
    else                       status_o = ST_NONE;
  end
endmodule

// File: rtl/vnorm_step.sv
module vnorm_step
  import vnorm_pkg::*;
#(
  parameter int CW        = 5,
  parameter int CNT_MAX   = 27,
  parameter int NEAR_MIN  = 12,
  parameter int FAST_LO   = 10,
  parameter int FAST_HI   = 26,
  parameter int FAST_STEP = 2
) (
  input  logic [CW-1:0]  cnt_i,
  input  logic           miss_mem_i,
  input  logic           found_i,
  input  vnorm_status_e  status_i,
  output logic [CW-1:0]  cnt_o,
  output logic           miss_mem_o
);
  localparam logic [CW-1:0] CntMax  = CW'(CNT_MAX);
  localparam logic [CW-1:0] FastLo  = CW'(FAST_LO);
  localparam logic [CW-1:0] FastHi  = CW'(FAST_HI);
  localparam logic [CW-1:0] Floor   = CW'(NEAR_MIN - 1);
  localparam logic [CW-1:0] BigStep = CW'(FAST_STEP);

  logic          upper;
  logic          hit_eff;
  logic [CW-1:0] dn_amt;
  logic [CW-1:0] dn_raw;

  assign upper   = (status_i != ST_NONE);
  // a good pulse right after a bad one is scored as bad in the upper bands
  assign hit_eff = found_i && !(miss_mem_i && upper);

  always_comb begin
    dn_amt = (cnt_i > FastLo && cnt_i < FastHi) ? BigStep : CW'(1);
    dn_raw = (cnt_i >= dn_amt) ? cnt_i - dn_amt : '0;
    if (hit_eff)
      cnt_o = (cnt_i >= CntMax) ? CntMax : cnt_i + CW'(1);
    else if (upper && dn_raw < Floor)
      cnt_o = Floor;
    else
      cnt_o = dn_raw;
  end

  assign miss_mem_o = !found_i;
endmodule

// File: rtl/vnorm_counter.sv
module vnorm_counter
  import vnorm_pkg::*;
#(
  parameter int CNT_MAX    = 27,
  parameter int NEAR_MIN   = 12,
  parameter int NORM_ABOVE = 22,
  parameter int FAST_LO    = 10,
  parameter int FAST_HI    = 26,
  parameter int FAST_STEP  = 2,
  localparam int CW        = $clog2(CNT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          field_end_i,
  input  logic          vsync_found_i,
  input  logic          sync_lost_i,
  input  logic          force_wide_i,
  output logic [1:0]    status_o,
  output logic          norm_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          miss_q, miss_d;
  logic          clear;
  vnorm_status_e status;

  assign clear = sync_lost_i || force_wide_i;

  vnorm_classify #(
    .CW(CW), .NEAR_MIN(NEAR_MIN), .NORM_ABOVE(NORM_ABOVE)
  ) u_classify (
    .cnt_i(cnt_q), .status_o(status)
  );

  vnorm_step #(
    .CW(CW), .CNT_MAX(CNT_MAX), .NEAR_MIN(NEAR_MIN),
    .FAST_LO(FAST_LO), .FAST_HI(FAST_HI), .FAST_STEP(FAST_STEP)
  ) u_step (
    .cnt_i(cnt_q), .miss_mem_i(miss_q), .found_i(vsync_found_i),
    .status_i(status), .cnt_o(cnt_d), .miss_mem_o(miss_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (field_end_i) begin
      cnt_q  <= cnt_d;
      miss_q <= miss_d;
    end
  end

  assign status_o = status;
  assign norm_o   = (status == ST_NORM);
  assign count_o  = cnt_q;

  // checks
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CNT_MAX));

  assert_hit_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end_i && !clear && vsync_found_i && status == ST_NONE)
    |=> ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + (CW+1)'(1)));

  assert_miss_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end_i && !clear && !vsync_found_i && cnt_q != '0)
    |=> (cnt_q < $past(cnt_q)));

  assert_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_end_i && !clear && cnt_q >= CW'(NEAR_MIN))
    |=> (cnt_q >= CW'(NEAR_MIN - 1)));

  assert_norm_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_o == (cnt_q > CW'(NORM_ABOVE)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!field_end_i && !clear) |=> $stable(cnt_q));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> (cnt_q == '0 && status_o == 2'b00));
endmodule

// File: tb/vnorm_counter_tb.sv
`timescale 1ns/1ps
module vnorm_counter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       field_end_i = 1'b0;
  logic       vsync_found_i = 1'b0;
  logic       sync_lost_i = 1'b0;
  logic       force_wide_i = 1'b0;
  logic [1:0] status_o;
  logic       norm_o;
  logic [4:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  vnorm_counter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .field_end_i(field_end_i),
    .vsync_found_i(vsync_found_i), .sync_lost_i(sync_lost_i),
    .force_wide_i(force_wide_i), .status_o(status_o), .norm_o(norm_o),
    .count_o(count_o)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_status(int c);
    if (c > 22) return 2;
    if (c >= 12) return 1;
    return 0;
  endfunction

  // one field strobe; returns at a negedge after the update edge
  task automatic field(bit found);
    @(negedge clk_i);
    field_end_i = 1'b1;
    vsync_found_i = found;
    @(negedge clk_i);
    field_end_i = 1'b0;
    vsync_found_i = 1'b0;
  endtask

  task automatic fld_chk(bit found, int exp, string req);
    field(found);
    check(req, count_o, exp);
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 0);
    check("R1 status", status_o, 0);
    check("R1 norm", norm_o, 0);
  endtask

  task automatic t_climb();
    for (int i = 1; i <= 28; i++) begin
      field(1'b1);
      check("R2 up", count_o, i > 27 ? 27 : i);
      check("R6 status", status_o, exp_status(i > 27 ? 27 : i));
      check("R7 norm", norm_o, (i > 22) ? 1 : 0);
    end
  endtask

  task automatic t_descend();
    fld_chk(1'b0, 26, "R3 by one at 27");
    fld_chk(1'b1, 25, "R4 penalised hit");
    fld_chk(1'b1, 26, "R4 second hit counts");
    fld_chk(1'b0, 25, "R3 by one at 26");
    fld_chk(1'b0, 23, "R3 by two at 25");
    for (int e = 21; e >= 11; e -= 2)
      fld_chk(1'b0, e, "R3 by two band");
    check("R6 no-norm at 11", status_o, 0);
    fld_chk(1'b1, 12, "R4 no penalty in no-norm");
    check("R6 near at 12", status_o, 1);
    fld_chk(1'b0, 11, "R5 floor at 11");
    fld_chk(1'b0, 9, "R3 by two at 11");
    for (int e = 8; e >= 0; e--)
      fld_chk(1'b0, e, "R3 by one low");
    fld_chk(1'b0, 0, "R3 floor 0");
  endtask

  task automatic t_no_strobe();
    for (int i = 0; i < 3; i++) field(1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      vsync_found_i = i[0];
    end
    @(negedge clk_i);
    vsync_found_i = 1'b0;
    check("R8 hold without strobe", count_o, 3);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 12; i++) field(1'b1);
    check("R9 pre count", count_o, 15);
    @(negedge clk_i);
    sync_lost_i = 1'b1;
    @(negedge clk_i);
    sync_lost_i = 1'b0;
    check("R9 cleared", count_o, 0);
    check("R9 status", status_o, 0);
    for (int i = 0; i < 5; i++) field(1'b1);
    force_wide_i = 1'b1;
    @(negedge clk_i);
    check("R10 forced clear", count_o, 0);
    for (int i = 0; i < 3; i++) begin
      field(1'b1);
      check("R10 held", count_o, 0);
    end
    force_wide_i = 1'b0;
    fld_chk(1'b1, 1, "R10 release");
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_climb();
    t_descend();
    t_no_strobe();
    t_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule